// File: doc/BRIEF.md
# Unsigned Dadda Tree Multiplier

This block multiplies two unsigned operands and returns their full-width product one clock after the operands are presented. The operands may differ in width. Both are zero-extended to the wider width N, so the product is 2N bits wide. An array of AND gates forms every partial-product bit. The bits are sorted into columns by weight, and a Dadda height-reduction tree of half and full adders brings every column down to at most two bits. A carry-lookahead adder then sums the two remaining rows.

The tree uses the minimal Dadda rule. Each stage has a target column height taken from the series 2, 3, 4, 6, 9, 13, and so on, where each term is the floor of 1.5 times the one before it. The first stage uses the largest term below N. A column that sits exactly one bit above the target gets a half adder. A taller column gets full adders, repeatedly, until it is no taller than the target. Column 0 always holds a single bit and bypasses the adder. For N of 2 the final addition is two chained half adders. For N of 1 the upper product bit is constant zero.

The result is captured in an output register. A valid strobe travels with the data and loads that register, and the register holds its value while no new operands arrive.

Top module: `dadda_mult`

## Requirements
- R1: While the synchronous active-high reset is high, the next clock edge clears `out_valid` to 0 and `product` to all zeros.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge, so each accepted operand pair yields exactly one result, one cycle later.
- R3: For equal operand widths of 3 bits or more, `product` equals the unsigned product `op_a * op_b` of the pair accepted one cycle earlier.
- R4: When the operand widths differ, the narrower operand is zero-extended, the product port is twice the larger width, and the product is still exact.
- R5: In a cycle following one where `in_valid` was 0, `product` keeps its previous value, whatever the operand inputs carried.
- R6: Both operands all ones give the largest product, (2^N-1)^2, and the final adder never produces a carry out of its top bit.
- R7: A zero operand on either side gives an all-zero product.
- R8: With 2-bit operands, the chained half-adder path produces the exact 4-bit product for all 16 operand pairs.
- R9: Product bit 0 equals bit 0 of `op_a` ANDed with bit 0 of `op_b` from the accepted pair.
- R10: With 1-bit operands, product bit 1 is always 0 and bit 0 is the AND of the two operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on `op_a` and `op_b` are accepted this cycle |
| op_a | input | A_W | First unsigned operand |
| op_b | input | B_W | Second unsigned operand |
| out_valid | output | 1 | `product` carries a new result this cycle |
| product | output | 2*max(A_W,B_W) | Registered unsigned product |

## Verification
The bound checker watches four things on every cycle. It checks that the valid strobe is delayed by exactly one cycle, that the output holds while idle, that bit 0 follows the AND of the operands' low bits, and that a zero operand gives a zero product. It also checks that the final adder's carry-out is never set and that reset clears the outputs. Whether the complete product is correct cannot be judged from one cycle's signals. That is shown by the bench scenarios: every operand pair for 1-, 2-, 3x2- and 4-bit configurations, and random pairs plus corner pairs for 8x8, 12x5 and 16x16 configurations, all compared against a reference multiplication.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

  // Upper bound on the length of the height series; far beyond any real width.
  localparam int SEQ_LIMIT = 40;

  // Target column height of reduction stage idx (idx = 1 is the last stage).
  function automatic int dadda_term(input int idx);
    int d;
    d = 2;
    for (int k = 1; k < SEQ_LIMIT; k++) begin
      if (k < idx) d = (d * 3) / 2;
    end
    return d;
  endfunction

  // Number of reduction stages for operand width n: count of targets below n.
  function automatic int dadda_stages(input int n);
    int s;
    s = 0;
    for (int j = 1; j < SEQ_LIMIT; j++) begin
      if (dadda_term(j) < n) s = j;
    end
    return s;
  endfunction

  function automatic int wmax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/dadda_pp.sv
// Partial-product array: pp[i][j] = a[i] & b[j], weight 2^(i+j).
module dadda_pp #(
  parameter int N = 8
) (
  input  logic [N-1:0]          a,
  input  logic [N-1:0]          b,
  output logic [N-1:0][N-1:0]   pp
);

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign pp[i][j] = a[i] & b[j];
    end
  end

endmodule

// File: rtl/dadda_reduce.sv
// Dadda height reduction. Heights depend only on N, so every index below is
// a constant once the loops are unrolled; only the bit values are logic.
// Bits are taken from the bottom of a column (oldest first) and new sums and
// carries are appended at the top, so fresh results wait for a later stage.
module dadda_reduce #(
  parameter int N = 8,
  localparam int COLS   = 2 * N,
  localparam int DEPTH  = 4 * N + 4,
  localparam int STAGES = dadda_pkg::dadda_stages(N),
  localparam int IW     = $clog2(DEPTH),
  localparam int CW     = $clog2(COLS + 1)
) (
  input  logic [N-1:0][N-1:0] pp,
  output logic [COLS-1:0]     row_x,
  output logic [COLS-1:0]     row_y
);

  logic bits [COLS+1][DEPTH];
  int   base_q [COLS+1];
  int   top_q  [COLS+1];

  always_comb begin
    int   h;
    int   lim;
    int   nxt;
    logic x0;
    logic x1;
    logic x2;

    h   = 0;
    lim = 0;
    nxt = 0;
    x0  = 1'b0;
    x1  = 1'b0;
    x2  = 1'b0;

    for (int c = 0; c <= COLS; c++) begin
      base_q[c] = 0;
      top_q[c]  = 0;
      for (int k = 0; k < DEPTH; k++) bits[c][k] = 1'b0;
    end

    // Sort partial products into columns by weight.
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (top_q[i+j] < DEPTH) bits[CW'(i+j)][IW'(top_q[i+j])] = pp[i][j];
        top_q[i+j] = top_q[i+j] + 1;
      end
    end

    // Stages run from the tallest target down to height two.
    for (int st = 0; st < STAGES; st++) begin
      lim = dadda_pkg::dadda_term(STAGES - st);
      for (int c = 0; c < COLS; c++) begin
        nxt = c + 1;
        for (int r = 0; r <= N; r++) begin
          h = top_q[c] - base_q[c];
          if (h == lim + 1) begin
            // Half adder: column shrinks by one, next column grows by one.
            x0 = bits[CW'(c)][IW'(base_q[c])];
            x1 = bits[CW'(c)][IW'(base_q[c] + 1)];
            base_q[c] = base_q[c] + 2;
            if (top_q[c] < DEPTH) bits[CW'(c)][IW'(top_q[c])] = x0 ^ x1;
            top_q[c] = top_q[c] + 1;
            if (top_q[nxt] < DEPTH) bits[CW'(nxt)][IW'(top_q[nxt])] = x0 & x1;
            top_q[nxt] = top_q[nxt] + 1;
          end else if (h > lim) begin
            // Full adder: column shrinks by two, next column grows by one.
            x0 = bits[CW'(c)][IW'(base_q[c])];
            x1 = bits[CW'(c)][IW'(base_q[c] + 1)];
            x2 = bits[CW'(c)][IW'(base_q[c] + 2)];
            base_q[c] = base_q[c] + 3;
            if (top_q[c] < DEPTH) bits[CW'(c)][IW'(top_q[c])] = x0 ^ x1 ^ x2;
            top_q[c] = top_q[c] + 1;
            if (top_q[nxt] < DEPTH)
              bits[CW'(nxt)][IW'(top_q[nxt])] = (x0 & x1) | (x2 & (x0 ^ x1));
            top_q[nxt] = top_q[nxt] + 1;
          end
        end
      end
    end

    // At most two bits remain per column; missing positions read as zero.
    for (int c = 0; c < COLS; c++) begin
      h = top_q[c] - base_q[c];
      row_x[c] = (h >= 1) ? bits[CW'(c)][IW'(base_q[c])]     : 1'b0;
      row_y[c] = (h >= 2) ? bits[CW'(c)][IW'(base_q[c] + 1)] : 1'b0;
    end
  end

endmodule

// File: rtl/dadda_cla.sv
// Carry-lookahead adder: per-group generate/propagate, group carries chained
// at group level, bit carries expanded from the group carry inside a group.
module dadda_cla #(
  parameter int W   = 15,
  parameter int GRP = 4,
  localparam int NG = (W + GRP - 1) / GRP
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W-1:0] p;
  logic [W-1:0] g;
  logic [NG:0]  cg;

  always_comb begin
    logic grp_g;
    logic grp_p;
    logic acc;

    p     = x ^ y;
    g     = x & y;
    cg    = '0;
    sum   = '0;
    grp_g = 1'b0;
    grp_p = 1'b1;
    acc   = 1'b0;

    for (int gi = 0; gi < NG; gi++) begin
      grp_g = 1'b0;
      grp_p = 1'b1;
      for (int t = 0; t < GRP; t++) begin
        if (gi * GRP + t < W) begin
          // Carry into this bit, built from the group carry and local terms.
          acc = cg[gi];
          for (int u = 0; u < GRP; u++) begin
            if (u < t) acc = g[gi*GRP+u] | (p[gi*GRP+u] & acc);
          end
          sum[gi*GRP+t] = p[gi*GRP+t] ^ acc;
          grp_g = g[gi*GRP+t] | (p[gi*GRP+t] & grp_g);
          grp_p = grp_p & p[gi*GRP+t];
        end
      end
      cg[gi+1] = grp_g | (grp_p & cg[gi]);
    end
  end

  assign cout = cg[NG];

endmodule

// File: rtl/dadda_mult.sv
module dadda_mult #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  localparam int N  = dadda_pkg::wmax(A_W, B_W),
  localparam int PW = 2 * N
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [A_W-1:0] op_a,
  input  logic [B_W-1:0] op_b,
  output logic           out_valid,
  output logic [PW-1:0]  product
);

  logic [N-1:0]        a_ext;
  logic [N-1:0]        b_ext;
  logic [N-1:0][N-1:0] pp;
  logic [PW-1:0]       prod_c;
  logic                fin_cout;

  assign a_ext = N'(op_a);
  assign b_ext = N'(op_b);

  dadda_pp #(.N(N)) u_pp (
    .a  (a_ext),
    .b  (b_ext),
    .pp (pp)
  );

  if (N == 1) begin : g_w1
    assign prod_c   = {1'b0, pp[0][0]};
    assign fin_cout = 1'b0;
  end else if (N == 2) begin : g_w2
    logic s1, c1, s2, c2;
    assign s1       = pp[1][0] ^ pp[0][1];
    assign c1       = pp[1][0] & pp[0][1];
    assign s2       = c1 ^ pp[1][1];
    assign c2       = c1 & pp[1][1];
    assign prod_c   = {c2, s2, s1, pp[0][0]};
    assign fin_cout = 1'b0;
  end else begin : g_wide
    logic [PW-1:0] row_x;
    logic [PW-1:0] row_y;
    logic [PW-2:0] upper;

    dadda_reduce #(.N(N)) u_reduce (
      .pp    (pp),
      .row_x (row_x),
      .row_y (row_y)
    );

    dadda_cla #(.W(PW - 1)) u_cla (
      .x    (row_x[PW-1:1]),
      .y    (row_y[PW-1:1]),
      .sum  (upper),
      .cout (fin_cout)
    );

    // Column 0 holds only a0&b0; row_y[0] is always empty.
    assign prod_c = {upper, row_x[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= prod_c;
    end
  end

endmodule

// File: rtl/dadda_mult_chk.sv
module dadda_mult_chk #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int PW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [A_W-1:0] op_a,
  input logic [B_W-1:0] op_b,
  input logic           out_valid,
  input logic [PW-1:0]  product,
  input logic           fin_cout
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && product == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(product));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    !fin_cout);

  assert_zero_operand_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_a == '0 || op_b == '0)) |=> (product == '0));

  assert_low_bit_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (product[0] == ($past(op_a[0]) & $past(op_b[0]))));

endmodule

bind dadda_mult dadda_mult_chk #(.A_W(A_W), .B_W(B_W), .PW(PW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .product   (product),
  .fin_cout  (fin_cout)
);

// File: tb/test_dadda_mult.sv
// One scoreboard harness per operand configuration.
module mult_harness #(
  parameter int    A_W      = 4,
  parameter int    B_W      = 4,
  parameter bit    EXH      = 1'b1,
  parameter int    NVEC     = 200,
  parameter string MAIN_TAG = "R3",
  localparam int   N        = (A_W > B_W) ? A_W : B_W,
  localparam int   PW       = 2 * N
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   checks,
  output int   errors
);

  logic           in_valid;
  logic [A_W-1:0] op_a;
  logic [B_W-1:0] op_b;
  logic           out_valid;
  logic [PW-1:0]  product;

  logic [PW-1:0]  q_exp [$];
  string          q_tag [$];
  logic [PW-1:0]  last_prod;
  logic           saw_pos;
  int             sent;

  dadda_mult #(.A_W(A_W), .B_W(B_W)) i_dadda_mult (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
  );

  initial begin
    checks    = 0;
    errors    = 0;
    saw_pos   = 1'b0;
    last_prod = '0;
  end

  task automatic note(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (A_W=%0d B_W=%0d): actual %0h expected %0h",
               tag, A_W, B_W, act, exp);
    end
  endtask

  task automatic drive(input logic [A_W-1:0] a, input logic [B_W-1:0] b);
    logic [PW-1:0] e;
    string t;
    @(negedge clk);
    op_a     = a;
    op_b     = b;
    in_valid = 1'b1;
    e = PW'(a) * PW'(b);
    if (a == '0 || b == '0)      t = "R7";
    else if ((&a) && (&b))       t = "R6";
    else                         t = MAIN_TAG;
    q_exp.push_back(e);
    q_tag.push_back(t);
    sent++;
    if (sent % 9 == 8) begin
      // Idle cycle with changed operands: must not disturb the output.
      @(negedge clk);
      in_valid = 1'b0;
      op_a     = ~a;
      op_b     = ~b;
    end
  endtask

  always @(posedge clk) saw_pos <= 1'b1;

  // Monitor: results appear one edge after acceptance, sampled at negedge.
  always @(negedge clk) begin
    if (rst) begin
      if (saw_pos)
        note(!out_valid && product == '0, "R1", 64'(product), 64'd0);
    end else if (out_valid) begin
      if (q_exp.size() == 0) begin
        note(1'b0, "R2", 64'(1), 64'(0));
      end else begin
        logic [PW-1:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        note(product == e, t, 64'(product), 64'(e));
        note(product[0] == e[0], "R9", 64'(product[0]), 64'(e[0]));
        if (N == 1) note(product[PW-1] == 1'b0, "R10", 64'(product), 64'(e));
        last_prod <= product;
      end
    end else begin
      note(product == last_prod, "R5", 64'(product), 64'(last_prod));
    end
  end

  initial begin
    done     = 1'b0;
    sent     = 0;
    in_valid = 1'b0;
    op_a     = '0;
    op_b     = '0;
    while (rst !== 1'b0) @(negedge clk);
    if (EXH) begin
      for (int ia = 0; ia < (1 << A_W); ia++) begin
        for (int ib = 0; ib < (1 << B_W); ib++) begin
          drive(A_W'(ia), B_W'(ib));
        end
      end
    end else begin
      drive('0, B_W'($urandom()));
      drive(A_W'($urandom()), '0);
      drive('1, '1);
      drive(A_W'(1), '1);
      drive('1, B_W'(1));
      for (int v = 0; v < NVEC; v++) begin
        drive(A_W'({$urandom(), $urandom()}), B_W'({$urandom(), $urandom()}));
      end
      drive('1, '1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    // R2: every accepted pair produced exactly one result.
    note(q_exp.size() == 0, "R2", 64'(q_exp.size()), 64'd0);
    done = 1'b1;
  end

endmodule

module test_dadda_mult;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NH         = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NH-1:0] done_v;
  int            chk_v [NH];
  int            err_v [NH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mult_harness #(.A_W(4),  .B_W(4),  .EXH(1'b1), .MAIN_TAG("R3"))
    h_4x4   (.clk(clk), .rst(rst), .done(done_v[0]), .checks(chk_v[0]), .errors(err_v[0]));
  mult_harness #(.A_W(8),  .B_W(8),  .EXH(1'b0), .NVEC(300), .MAIN_TAG("R3"))
    h_8x8   (.clk(clk), .rst(rst), .done(done_v[1]), .checks(chk_v[1]), .errors(err_v[1]));
  mult_harness #(.A_W(16), .B_W(16), .EXH(1'b0), .NVEC(300), .MAIN_TAG("R3"))
    h_16x16 (.clk(clk), .rst(rst), .done(done_v[2]), .checks(chk_v[2]), .errors(err_v[2]));
  mult_harness #(.A_W(12), .B_W(5),  .EXH(1'b0), .NVEC(200), .MAIN_TAG("R4"))
    h_12x5  (.clk(clk), .rst(rst), .done(done_v[3]), .checks(chk_v[3]), .errors(err_v[3]));
  mult_harness #(.A_W(3),  .B_W(2),  .EXH(1'b1), .MAIN_TAG("R4"))
    h_3x2   (.clk(clk), .rst(rst), .done(done_v[4]), .checks(chk_v[4]), .errors(err_v[4]));
  mult_harness #(.A_W(2),  .B_W(2),  .EXH(1'b1), .MAIN_TAG("R8"))
    h_2x2   (.clk(clk), .rst(rst), .done(done_v[5]), .checks(chk_v[5]), .errors(err_v[5]));
  mult_harness #(.A_W(1),  .B_W(1),  .EXH(1'b1), .MAIN_TAG("R10"))
    h_1x1   (.clk(clk), .rst(rst), .done(done_v[6]), .checks(chk_v[6]), .errors(err_v[6]));

  initial begin
    int total_checks;
    int total_errors;
    bit timed_out;
    timed_out = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fork
      begin
        wait (&done_v);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    total_checks = 0;
    total_errors = 0;
    for (int k = 0; k < NH; k++) begin
      total_checks += chk_v[k];
      total_errors += err_v[k];
    end
    if (timed_out) begin
      total_checks++;
      total_errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", total_checks, total_errors);
    $finish;
  end

endmodule